// File: doc/BRIEF.md
# Set-Associative Tag Directory

This block keeps the tags of a set-associative cache and nothing else: no data is held. Each request carries one address, and the block answers whether that address's block is already present. When it is not, a way of the indexed set is claimed for it at once, so a later access to the same block finds it. The directory can sit beside a memory model or a performance monitor that needs realistic hit and miss behaviour without paying for data storage.

An address is divided into a byte offset inside the block, a set index, and the tag bits above them. The stored tag is the address with the set and offset bits forced to zero; it is not shifted down. On a miss the lowest-numbered empty way is taken first. Only when the set is full does the replacement scheme pick a victim. The scheme is fixed at elaboration by `POLICY`: least recently used, first in first out, or pseudo-random from a free-running 16-bit LFSR. The set count is `CACHE_BYTES / (BLK_BYTES * WAYS)`. The block size and the way count must be powers of two, and there must be at least two sets. Two counters give the running number of lookups and of misses.

The response controller has three states. `ST_IDLE` means no response is shown. `ST_HIT` shows a hit and `ST_MISS` shows a miss. The transitions are the same from every state: an accepted request with a matching valid way moves to `ST_HIT`, an accepted request without one moves to `ST_MISS`, and a cycle with no accepted request returns to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `tag_directory`

## Requirements
- R1: A synchronous reset with `rst_n` low clears every valid bit, both counters and all replacement state. After it, `rsp_valid` is low, both counters read 0, and the first access to any address is a miss.
- R2: With the default geometry, bits [5:0] are the byte offset, bits [10:6] are the set index and bits [31:11] are the tag. Two addresses that differ only in offset bits name the same block. The stored tag is the address with bits [10:0] cleared.
- R3: A lookup hits only if some way of the indexed set is valid and holds an equal stored tag. The same tag bits under a different set index miss.
- R4: From the second cycle after reset release, `req_ready` is high. Every request accepted (`req_valid` and `req_ready` high at a clock edge) raises `rsp_valid` for exactly the following cycle. `rsp_valid` is never high otherwise.
- R5: On a miss, the lowest-numbered invalid way of the set is filled with the new tag and marked valid. The response reports a miss, and `rsp_way` gives the filled way; on a hit it gives the matching way. A request accepted in the very next cycle to the same block hits.
- R6: With `POLICY` = `REPL_LRU` and the set full, a miss replaces the way whose last access (hit or fill) is the oldest.
- R7: With `POLICY` = `REPL_FIFO` and the set full, a miss replaces the way filled earliest. Hits do not change that order.
- R8: With `POLICY` = `REPL_RAND` and the set full, the victim way is taken from the low bits of a free-running 16-bit LFSR. The newly placed block hits when accessed again.
- R9: `access_count` rises by one after each accepted request and holds otherwise.
- R10: `miss_count` rises by one in the response cycle of a miss. It holds on hits and in idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A lookup request is present |
| req_ready | output | 1 | The block accepts a request this cycle |
| req_addr | input | ADDR_W | Byte address to look up |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_hit | output | 1 | 1 = hit, 0 = miss (block now allocated) |
| rsp_way | output | $clog2(WAYS) | Way that hit or was filled |
| access_count | output | CNT_W | Running count of lookups |
| miss_count | output | CNT_W | Running count of misses |

## Verification
In the same cycle, the block shows one request's response and its counter update while it accepts the next request and writes the allocation for it. The next lookup must therefore see the tag written at that very edge. This is provoked with back-to-back requests: a cold miss followed at once by an offset variant of the same block, and long unbroken runs of random addresses over a few sets that keep those sets full. A scoreboard predicts hit, way and both counters for every response, from a bench-side model for the LRU and FIFO instances. The random-policy instance is judged only where the outcome is fixed: fills before a set is full, and the re-access of a block that has just been placed.

// File: rtl/cdir_pkg.sv
package cdir_pkg;

    typedef enum logic [1:0] {
        REPL_LRU  = 2'd0,
        REPL_FIFO = 2'd1,
        REPL_RAND = 2'd2
    } repl_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } dir_state_e;

    // maximal-length 16-bit Fibonacci LFSR, taps 16,14,13,11
    function automatic logic [15:0] lfsr16_step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

endpackage

// File: rtl/cdir_tag_store.sv
module cdir_tag_store #(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 8,
    parameter int SETS   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(SETS)-1:0]       rd_set,
    input  logic                          wr_en,
    input  logic [$clog2(WAYS)-1:0]       wr_way,
    input  logic [ADDR_W-1:0]             wr_tag,
    output logic [WAYS-1:0][ADDR_W-1:0]   rd_tags,
    output logic [WAYS-1:0]               rd_valid
);

    localparam int SET_W = $clog2(SETS);

    logic [ADDR_W-1:0] tag_mem   [SETS][WAYS];
    logic [WAYS-1:0]   valid_mem [SETS];

    // writes always go to the set being read (allocation in lookup cycle)
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[rd_set][wr_way] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_mem[s] <= '0;
            end
        end else if (wr_en) begin
            valid_mem[rd_set][wr_way] <= 1'b1;
        end
    end

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_rd
            assign rd_tags[w] = tag_mem[rd_set][w];
        end
    endgenerate

    assign rd_valid = valid_mem[rd_set];

    logic [SET_W-1:0] unused_store;
    assign unused_store = '0;

endmodule

// File: rtl/cdir_match.sv
module cdir_match #(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 8
) (
    input  logic [WAYS-1:0][ADDR_W-1:0] tags,
    input  logic [WAYS-1:0]             valid,
    input  logic [ADDR_W-1:0]           probe_tag,
    output logic                        hit,
    output logic [$clog2(WAYS)-1:0]     hit_way,
    output logic                        has_free,
    output logic [$clog2(WAYS)-1:0]     free_way
);

    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0] match_vec;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match_vec[w] = valid[w] && (tags[w] == probe_tag);
        end
    endgenerate

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    // lowest-numbered empty way wins
    always_comb begin
        has_free = ~&valid;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                free_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/cdir_victim.sv
module cdir_victim
    import cdir_pkg::*;
#(
    parameter int    WAYS   = 8,
    parameter int    SETS   = 32,
    parameter repl_e POLICY = REPL_LRU
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  set_idx,
    input  logic                     access_en,
    input  logic                     evict_en,
    input  logic [$clog2(WAYS)-1:0]  used_way,
    output logic [$clog2(WAYS)-1:0]  victim_way
);

    localparam int WAY_W = $clog2(WAYS);

    generate
        if (POLICY == REPL_LRU) begin : g_lru
            // per-way age rank, 0 = newest, WAYS-1 = oldest; a permutation per set
            logic [WAY_W-1:0] age_mem [SETS][WAYS];
            logic [WAY_W-1:0] cur_age [WAYS];
            logic [WAY_W-1:0] nxt_age [WAYS];
            logic [WAY_W-1:0] touched_age;

            always_comb begin
                for (int w = 0; w < WAYS; w++) begin
                    cur_age[w] = age_mem[set_idx][w];
                end
                touched_age = cur_age[used_way];
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == used_way) begin
                        nxt_age[w] = '0;
                    end else if (cur_age[w] < touched_age) begin
                        nxt_age[w] = cur_age[w] + 1'b1;
                    end else begin
                        nxt_age[w] = cur_age[w];
                    end
                end
            end

            always_comb begin
                victim_way = '0;
                for (int w = 0; w < WAYS; w++) begin
                    if (cur_age[w] == WAY_W'(WAYS - 1)) begin
                        victim_way = WAY_W'(w);
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < SETS; s++) begin
                        for (int w = 0; w < WAYS; w++) begin
                            age_mem[s][w] <= WAY_W'(w);
                        end
                    end
                end else if (access_en) begin
                    for (int w = 0; w < WAYS; w++) begin
                        age_mem[set_idx][w] <= nxt_age[w];
                    end
                end
            end

            logic unused_lru;
            assign unused_lru = evict_en;
        end else if (POLICY == REPL_FIFO) begin : g_fifo
            // fills happen lowest-first, so fill order is a rotation per set
            logic [WAY_W-1:0] head_mem [SETS];

            assign victim_way = head_mem[set_idx];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < SETS; s++) begin
                        head_mem[s] <= '0;
                    end
                end else if (access_en && evict_en) begin
                    head_mem[set_idx] <= used_way + 1'b1;
                end
            end
        end else begin : g_rand
            logic [15:0] lfsr_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lfsr_q <= 16'hACE1;
                end else begin
                    lfsr_q <= lfsr16_step(lfsr_q);
                end
            end

            assign victim_way = lfsr_q[WAY_W-1:0];

            logic unused_rand;
            assign unused_rand = ^{set_idx, access_en, evict_en, used_way};
        end
    endgenerate

endmodule

// File: rtl/tag_directory.sv
module tag_directory
    import cdir_pkg::*;
#(
    parameter int    ADDR_W      = 32,
    parameter int    WAYS        = 8,
    parameter int    BLK_BYTES   = 64,
    parameter int    CACHE_BYTES = 16384,
    parameter repl_e POLICY      = REPL_LRU,
    parameter int    CNT_W       = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [$clog2(WAYS)-1:0]  rsp_way,
    output logic [CNT_W-1:0]         access_count,
    output logic [CNT_W-1:0]         miss_count
);

    localparam int SETS  = CACHE_BYTES / (BLK_BYTES * WAYS);
    localparam int OFF_W = $clog2(BLK_BYTES);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int LOW_W = OFF_W + SET_W;
    localparam logic [ADDR_W-1:0] TAG_MASK = {ADDR_W{1'b1}} << LOW_W;

    // ---------------- address split ----------------
    logic [SET_W-1:0]  set_idx;
    logic [ADDR_W-1:0] probe_tag;
    logic              accept;

    assign set_idx   = req_addr[OFF_W +: SET_W];
    assign probe_tag = req_addr & TAG_MASK;
    assign accept    = req_valid && req_ready;

    // ---------------- tag store and compare ----------------
    logic [WAYS-1:0][ADDR_W-1:0] set_tags;
    logic [WAYS-1:0]             set_valid;
    logic                        lk_hit;
    logic [WAY_W-1:0]            lk_hit_way;
    logic                        lk_has_free;
    logic [WAY_W-1:0]            lk_free_way;
    logic [WAY_W-1:0]            pol_victim;
    logic [WAY_W-1:0]            fill_way;
    logic [WAY_W-1:0]            used_way;
    logic                        do_fill;
    logic                        do_evict;

    cdir_tag_store #(
        .ADDR_W (ADDR_W),
        .WAYS   (WAYS),
        .SETS   (SETS)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (set_idx),
        .wr_en    (do_fill),
        .wr_way   (fill_way),
        .wr_tag   (probe_tag),
        .rd_tags  (set_tags),
        .rd_valid (set_valid)
    );

    cdir_match #(
        .ADDR_W (ADDR_W),
        .WAYS   (WAYS)
    ) u_match (
        .tags      (set_tags),
        .valid     (set_valid),
        .probe_tag (probe_tag),
        .hit       (lk_hit),
        .hit_way   (lk_hit_way),
        .has_free  (lk_has_free),
        .free_way  (lk_free_way)
    );

    cdir_victim #(
        .WAYS   (WAYS),
        .SETS   (SETS),
        .POLICY (POLICY)
    ) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_idx    (set_idx),
        .access_en  (accept),
        .evict_en   (do_evict),
        .used_way   (used_way),
        .victim_way (pol_victim)
    );

    // empty way first; the policy is asked only when the set is full
    assign fill_way = lk_has_free ? lk_free_way : pol_victim;
    assign used_way = lk_hit ? lk_hit_way : fill_way;
    assign do_fill  = accept && !lk_hit;
    assign do_evict = do_fill && !lk_has_free;

    // ---------------- response controller ----------------
    dir_state_e state_q, state_d;
    logic       ready_q;
    logic [WAY_W-1:0] way_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_HIT, ST_MISS: begin
                if (accept) begin
                    state_d = lk_hit ? ST_HIT : ST_MISS;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
                rsp_hit   = 1'b0;
            end
            ST_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
            end
            ST_MISS: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b0;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_hit   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            way_q   <= '0;
        end else begin
            ready_q <= 1'b1;
            if (accept) begin
                way_q <= used_way;
            end
        end
    end

    assign req_ready = ready_q;
    assign rsp_way   = way_q;

    // ---------------- counters ----------------
    logic [CNT_W-1:0] acc_q, miss_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            miss_q <= '0;
        end else if (accept) begin
            acc_q <= acc_q + 1'b1;
            if (!lk_hit) begin
                miss_q <= miss_q + 1'b1;
            end
        end
    end

    assign access_count = acc_q;
    assign miss_count   = miss_q;

endmodule

// File: rtl/cdir_checker.sv
module cdir_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [CNT_W-1:0] access_count,
    input logic [CNT_W-1:0] miss_count
);

    // R4
    rsp_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready));

    // R4
    accept_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R3
    hit_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R9
    access_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (access_count == $past(access_count) + CNT_W'(1)));

    // R9
    access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> $stable(access_count));

    // R10
    miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (miss_count == $past(miss_count) + (rsp_hit ? CNT_W'(0) : CNT_W'(1))));

    // R10
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $stable(miss_count));

endmodule

bind tag_directory cdir_checker #(.CNT_W(CNT_W)) u_cdir_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .access_count (access_count),
    .miss_count   (miss_count)
);

// File: tb/test_tag_directory.sv
`timescale 1ns/1ps
module test_tag_directory;
    import cdir_pkg::*;

    localparam int NW = 8;
    localparam int NS = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_addr = '0;

    logic l_ready, l_rv, l_hit; logic [2:0] l_way; logic [31:0] l_acc, l_miss;
    logic f_ready, f_rv, f_hit; logic [2:0] f_way; logic [31:0] f_acc, f_miss;
    logic r_ready, r_rv, r_hit; logic [2:0] r_way; logic [31:0] r_acc, r_miss;

    always #2 clk = ~clk;

    tag_directory #(.POLICY(REPL_LRU)) i_tag_directory (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(l_ready),
        .req_addr(req_addr), .rsp_valid(l_rv), .rsp_hit(l_hit), .rsp_way(l_way),
        .access_count(l_acc), .miss_count(l_miss));

    tag_directory #(.POLICY(REPL_FIFO)) i_tag_directory_fifo (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(f_ready),
        .req_addr(req_addr), .rsp_valid(f_rv), .rsp_hit(f_hit), .rsp_way(f_way),
        .access_count(f_acc), .miss_count(f_miss));

    tag_directory #(.POLICY(REPL_RAND)) i_tag_directory_rand (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r_ready),
        .req_addr(req_addr), .rsp_valid(r_rv), .rsp_hit(r_hit), .rsp_way(r_way),
        .access_count(r_acc), .miss_count(r_miss));

    int n_tests = 0;
    int n_fail  = 0;
    bit running = 1'b0;
    bit done    = 1'b0;

    // reference models: index 0 = LRU, 1 = FIFO
    bit          m_val [2][NS][NW];
    logic [31:0] m_tag [2][NS][NW];
    int unsigned m_stamp [2][NS][NW];
    int unsigned m_gen = 0;

    // scoreboard queues
    string q_req [$];
    bit    q_hl [$];
    int    q_wl [$];
    bit    q_hf [$];
    int    q_wf [$];
    bit    q_rc [$];
    int mon_acc = 0, mon_miss_l = 0, mon_miss_f = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input int tag, input int set, input int off);
        return (32'(tag) << 11) | (32'(set) << 6) | 32'(off);
    endfunction

    task automatic model_clear();
        for (int p = 0; p < 2; p++)
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < NW; w++) begin
                    m_val[p][s][w] = 1'b0;
                    m_tag[p][s][w] = '0;
                    m_stamp[p][s][w] = 0;
                end
        m_gen = 0;
    endtask

    // policy 0: stamp on every access (recency); policy 1: stamp on fill only
    task automatic model_access(input int p, input logic [31:0] a, output bit h, output int way);
        int s;
        logic [31:0] t;
        int best;
        s = int'(a[10:6]);
        t = a & 32'hFFFF_F800;
        h = 1'b0;
        way = -1;
        for (int w = 0; w < NW; w++)
            if (m_val[p][s][w] && m_tag[p][s][w] == t) begin
                h = 1'b1;
                way = w;
            end
        if (h) begin
            if (p == 0) m_stamp[p][s][way] = m_gen;
        end else begin
            for (int w = NW - 1; w >= 0; w--)
                if (!m_val[p][s][w]) way = w;
            if (way < 0) begin
                best = 0;
                for (int w = 1; w < NW; w++)
                    if (m_stamp[p][s][w] < m_stamp[p][s][best]) best = w;
                way = best;
            end
            m_val[p][s][way] = 1'b1;
            m_tag[p][s][way] = t;
            m_stamp[p][s][way] = m_gen;
        end
        m_gen++;
    endtask

    // driver: predicts and pushes, then presents the request for one edge
    task automatic access(input logic [31:0] a, input string rq, input bit rand_known);
        bit hl, hf;
        int wl, wf;
        model_access(0, a, hl, wl);
        model_access(1, a, hf, wf);
        q_req.push_back(rq); q_hl.push_back(hl); q_wl.push_back(wl);
        q_hf.push_back(hf); q_wf.push_back(wf); q_rc.push_back(rand_known);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic reset_checks();
        chk("R1", "lru rsp_valid after reset", l_rv, 0);
        chk("R1", "fifo rsp_valid after reset", f_rv, 0);
        chk("R1", "rand rsp_valid after reset", r_rv, 0);
        chk("R1", "access_count after reset", l_acc, 0);
        chk("R1", "miss_count after reset", l_miss, 0);
        chk("R1", "fifo miss_count after reset", f_miss, 0);
        chk("R1", "rand access_count after reset", r_acc, 0);
        chk("R4", "req_ready after reset", l_ready & f_ready & r_ready, 1);
    endtask

    task automatic do_reset();
        idle(2);
        running = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        model_clear();
        q_req.delete(); q_hl.delete(); q_wl.delete();
        q_hf.delete(); q_wf.delete(); q_rc.delete();
        mon_acc = 0; mon_miss_l = 0; mon_miss_f = 0;
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks();
        running = 1'b1;
    endtask

    // monitor: pops the scoreboard as responses appear
    always @(negedge clk) begin
        if (rst_n && running) begin
            if (l_rv) begin
                if (q_req.size() == 0) begin
                    chk("R4", "response without request", 1, 0);
                end else begin
                    string rq; bit hl, hf, rc; int wl, wf;
                    rq = q_req.pop_front(); hl = q_hl.pop_front(); wl = q_wl.pop_front();
                    hf = q_hf.pop_front(); wf = q_wf.pop_front(); rc = q_rc.pop_front();
                    mon_acc++;
                    if (!hl) mon_miss_l++;
                    if (!hf) mon_miss_f++;
                    chk(rq, "lru hit", l_hit, hl);
                    chk(rq, "lru way", l_way, wl);
                    chk("R7", "fifo hit", f_hit, hf);
                    chk("R7", "fifo way", f_way, wf);
                    chk("R4", "fifo rsp_valid", f_rv, 1);
                    chk("R4", "rand rsp_valid", r_rv, 1);
                    if (rc) chk("R8", "rand hit", r_hit, hl);
                end
            end else begin
                chk("R4", "fifo idle rsp_valid", f_rv, 0);
                chk("R4", "rand idle rsp_valid", r_rv, 0);
            end
            chk("R9", "lru access_count", l_acc, mon_acc);
            chk("R9", "fifo access_count", f_acc, mon_acc);
            chk("R9", "rand access_count", r_acc, mon_acc);
            chk("R10", "lru miss_count", l_miss, mon_miss_l);
            chk("R10", "fifo miss_count", f_miss, mon_miss_f);
        end
    end

    initial begin
        #800000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        model_clear();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks();
        running = 1'b1;

        // cold miss, then back-to-back hit on an offset variant
        access(mk_addr(1, 0, 0), "R5", 1'b1);
        access(mk_addr(1, 0, 37), "R2", 1'b1);
        access(mk_addr(1, 1, 0), "R3", 1'b1);
        access(mk_addr(2, 0, 0), "R3", 1'b1);
        access(mk_addr(1, 1, 63), "R2", 1'b1);
        idle(3);

        // fill set 2, refresh one way, then force evictions
        for (int t = 1; t <= 8; t++) access(mk_addr(t, 2, 0), "R5", 1'b1);
        access(mk_addr(1, 2, 4), "R6", 1'b1);
        access(mk_addr(9, 2, 0), "R6", 1'b1);
        access(mk_addr(1, 2, 0), "R6", 1'b0);
        access(mk_addr(2, 2, 0), "R6", 1'b0);
        access(mk_addr(9, 2, 8), "R6", 1'b0);
        idle(2);

        // random policy: full set, new block must stick
        for (int t = 1; t <= 8; t++) access(mk_addr(t, 5, 0), "R5", 1'b1);
        access(mk_addr(20, 5, 0), "R8", 1'b1);
        access(mk_addr(20, 5, 9), "R8", 1'b1);
        idle(2);

        // random traffic over a few sets, mostly back to back
        seed = 32'h1234;
        for (int i = 0; i < 700; i++) begin
            int tg, st, of;
            tg = int'($urandom(seed) % 11) + 1; seed = seed + 7919;
            st = int'($urandom(seed) % 4);      seed = seed + 104729;
            of = int'($urandom(seed) % 64);     seed = seed + 31;
            access(mk_addr(tg, st, of), "R6", 1'b0);
            if (i % 37 == 0) idle(2);
        end
        idle(3);

        // reset mid-run: earlier blocks are forgotten
        do_reset();
        access(mk_addr(1, 0, 0), "R1", 1'b1);
        access(mk_addr(1, 0, 0), "R5", 1'b1);
        idle(3);

        chk("R4", "responses outstanding at end", q_req.size(), 0);
        running = 1'b0;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule